// File: doc/BRIEF.md
# Audio Automatic Level Control Loop

This block closes a digital gain loop around a programmable-gain amplifier that sits in front of an ADC. On each sample strobe it compares a signed level estimate with a programmed target level. It then moves a 6-bit gain code, in 0.75 dB steps, down quickly or up slowly. The code is kept between a programmed floor and a programmed ceiling. A two-bit select input decides which output channel, if any, follows the loop. Any channel that does not follow the loop passes the manual volume code straight through.

In ALC mode the gain climbs back once the signal has stayed quiet for a programmed hold time. The climb runs at a programmed decay rate. In limiter mode the loop only ever cuts gain below the value it had when the first overload arrived. The mode is sampled only while the loop is switched off, so the operating mode cannot change while the loop is running. Hold and decay lengths are counted in sample strobes. Their base lengths are parameters.

Top module: `alc_core`

## Requirements
- R1: `sel` routes the loop. 2'b00 means off. 2'b01 means the loop drives `gain_r` only. 2'b10 means the loop drives `gain_l` only. 2'b11 means the loop drives both outputs. `active` is 1 exactly when `sel` is not 2'b00.
- R2: A channel that the loop does not drive outputs its manual code (`man_l` or `man_r`). While `sel` is 2'b00, and on the first clock edge after `sel` changes, the loop gain loads the clamped manual code. That code is `man_r` when `sel` is 2'b01 and `man_l` otherwise.
- R3: Gain code g means -23.25 + 0.75·g dB. The maximum field m gives a ceiling code of 8·m+7, so m=0 gives -18 dB and m=7 gives +24 dB. The loop gain never exceeds this ceiling, and a manual code above it is cut to it on load.
- R4: The minimum field n gives a floor code of 8·n, so n=0 gives -23.25 dB and n=7 gives +18.75 dB. Attack never takes the loop gain below this floor.
- R5: `level` is signed, in 0.75 dB units. Target field t stands for the level -38+2·t, which is -28.5 dBFS at t=0 and -6 dBFS at t=15. On each strobe with `level` strictly above the target, the gain falls by one code and the hold count restarts. A level equal to the target counts as quiet.
- R6: Hold field h gives a hold length of 0 strobes when h=0 and HOLD_BASE·2^(h-1) strobes otherwise. No gain increase counting starts until that many quiet strobes have gone by.
- R7: Once the hold has elapsed, the gain rises by one code after every STEP_BASE·2^min(d,10) quiet strobes, where d is the decay field. Codes 10 to 15 all give the same rate.
- R8: In limiter mode, the first attack after the loop is enabled records the gain code held just before that attack. After that, the loop gain never rises above the recorded code.
- R9: The mode input (0 = ALC, 1 = limiter) is taken only while `sel` is 2'b00. A change made while the loop is on has no effect.
- R10: With `sel` = 2'b11, `gain_l` and `gain_r` always carry the same code.
- R11: The loop gain changes only on clock edges where `smp_stb` is high, apart from loading and clamping.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| smp_stb | input | 1 | One-cycle sample strobe |
| level | input | 8 | Signed level estimate, 0.75 dB units |
| sel | input | 2 | Loop channel select |
| mode_in | input | 1 | 0 ALC, 1 limiter (taken while off) |
| max_sel | input | 3 | Gain ceiling field |
| min_sel | input | 3 | Gain floor field |
| target_sel | input | 4 | Target level field |
| hold_sel | input | 4 | Hold length field |
| decay_sel | input | 4 | Decay rate field |
| man_l | input | 6 | Manual left gain code |
| man_r | input | 6 | Manual right gain code |
| gain_l | output | 6 | Left gain code |
| gain_r | output | 6 | Right gain code |
| active | output | 1 | Loop enabled |

## Verification
The loop is driven with runs of loud strobes, quiet strobes, strobes exactly at the target level, and cycles with no strobe. These runs separate the attack path, the equal-level comparison and strobe gating from one another. Quiet runs stop one strobe short of and exactly on the expected hold-plus-decay count, at a short decay code and at a saturated one. These runs confirm the doubling and the saturation of the decay rate. Limiter and ALC runs take the same recovery pattern after a single attack, so the ceiling and the mode latch show up as a difference in the final code.

// File: rtl/alc_pkg.sv
package alc_pkg;

    typedef logic [5:0] gain_t;

    typedef enum logic [1:0] {
        SEL_OFF   = 2'b00,
        SEL_RIGHT = 2'b01,
        SEL_LEFT  = 2'b10,
        SEL_BOTH  = 2'b11
    } alc_sel_e;

    typedef enum logic {
        MODE_ALC   = 1'b0,
        MODE_LIMIT = 1'b1
    } alc_mode_e;

    typedef struct packed {
        gain_t ceil_code;
        gain_t floor_code;
    } gain_bounds_t;

    // Ceiling: -18 dB + 6 dB * m, on the 0.75 dB grid from -23.25 dB
    function automatic gain_t max_code(input logic [2:0] m);
        return {m, 3'b111};
    endfunction

    // Floor: -23.25 dB + 6 dB * n
    function automatic gain_t min_code(input logic [2:0] n);
        return {n, 3'b000};
    endfunction

    // Target level in 0.75 dB units: -28.5 dBFS + 1.5 dB * t
    function automatic logic signed [7:0] target_lvl(input logic [3:0] t);
        return $signed({3'b000, t, 1'b0}) - 8'sd38;
    endfunction

    function automatic int unsigned hold_len(input logic [3:0] code, input int unsigned base);
        if (code == 4'd0) return 0;
        return base << (code - 4'd1);
    endfunction

    function automatic int unsigned step_len(input logic [3:0] code, input int unsigned base);
        return base << ((code > 4'd10) ? 4'd10 : code);
    endfunction

    function automatic gain_t clamp_gain(input gain_t g, input gain_bounds_t b);
        gain_t r;
        r = (g > b.ceil_code) ? b.ceil_code : g;
        r = (r < b.floor_code) ? b.floor_code : r;
        return r;
    endfunction

endpackage

// File: rtl/alc_timer.sv
module alc_timer #(
    parameter int unsigned HOLD_BASE = 128,
    parameter int unsigned STEP_BASE = 144,
    parameter int HW = 22,
    parameter int SW = 18
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       clr,
    input  logic       tick,
    input  logic       over,
    input  logic [3:0] hold_sel,
    input  logic [3:0] decay_sel,
    output logic       up
);
    logic [HW-1:0] hold_cnt;
    logic [HW-1:0] hold_lim;
    logic [SW-1:0] dec_cnt;
    logic [SW-1:0] step_lim;
    logic [SW:0]   dec_nx;
    logic          in_hold;

    assign hold_lim = HW'(alc_pkg::hold_len(hold_sel, HOLD_BASE));
    assign step_lim = SW'(alc_pkg::step_len(decay_sel, STEP_BASE));
    assign in_hold  = hold_cnt < hold_lim;
    assign dec_nx   = {1'b0, dec_cnt} + {{SW{1'b0}}, 1'b1};
    assign up       = tick && !over && !in_hold && (dec_nx >= {1'b0, step_lim});

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            hold_cnt <= '0;
            dec_cnt  <= '0;
        end else if (tick) begin
            if (over) begin
                hold_cnt <= '0;
                dec_cnt  <= '0;
            end else if (in_hold) begin
                hold_cnt <= hold_cnt + HW'(1);
            end else if (up) begin
                dec_cnt <= '0;
            end else begin
                dec_cnt <= dec_nx[SW-1:0];
            end
        end
    end
endmodule

// File: rtl/alc_gain.sv
module alc_gain
    import alc_pkg::*;
(
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  gain_t        load_val,
    input  logic         down,
    input  logic         up,
    input  alc_mode_e    mode,
    input  gain_bounds_t bnd,
    output gain_t        gain
);
    gain_t g_q, g_n, ceil_q, up_bound;
    logic  lim_q;

    always_comb begin
        up_bound = bnd.ceil_code;
        if (mode == MODE_LIMIT && lim_q && ceil_q < bnd.ceil_code)
            up_bound = ceil_q;
        g_n = g_q;
        if (load)
            g_n = load_val;
        else if (down)
            g_n = (g_q > bnd.floor_code) ? g_q - 6'd1 : g_q;
        else if (up)
            g_n = (g_q < up_bound) ? g_q + 6'd1 : g_q;
        g_n = clamp_gain(g_n, bnd);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            g_q    <= '0;
            ceil_q <= '0;
            lim_q  <= 1'b0;
        end else begin
            g_q <= g_n;
            if (load) begin
                lim_q <= 1'b0;
            end else if (down && mode == MODE_LIMIT && !lim_q) begin
                lim_q  <= 1'b1;
                ceil_q <= g_q;
            end
        end
    end

    assign gain = g_q;
endmodule

// File: rtl/alc_core.sv
module alc_core #(
    parameter int unsigned HOLD_BASE = 128,
    parameter int unsigned STEP_BASE = 144
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              smp_stb,
    input  logic signed [7:0] level,
    input  logic [1:0]        sel,
    input  logic              mode_in,
    input  logic [2:0]        max_sel,
    input  logic [2:0]        min_sel,
    input  logic [3:0]        target_sel,
    input  logic [3:0]        hold_sel,
    input  logic [3:0]        decay_sel,
    input  logic [5:0]        man_l,
    input  logic [5:0]        man_r,
    output logic [5:0]        gain_l,
    output logic [5:0]        gain_r,
    output logic              active
);
    import alc_pkg::*;

    localparam int HW = $clog2((HOLD_BASE << 14) + 1);
    localparam int SW = $clog2((STEP_BASE << 10) + 1);

    alc_sel_e     sel_e, sel_prev;
    alc_mode_e    mode_q;
    gain_bounds_t bnd;
    gain_t        load_val, loop_gain;
    logic         load, tick, over, up;

    assign sel_e  = alc_sel_e'(sel);
    assign active = (sel_e != SEL_OFF);
    assign load   = (sel_e == SEL_OFF) || (sel_e != sel_prev);
    assign tick   = smp_stb && active;
    assign over   = level > target_lvl(target_sel);

    assign bnd.ceil_code  = max_code(max_sel);
    assign bnd.floor_code = min_code(min_sel);
    assign load_val = clamp_gain((sel_e == SEL_RIGHT) ? man_r : man_l, bnd);

    always_ff @(posedge clk) begin
        if (rst) begin
            sel_prev <= SEL_OFF;
            mode_q   <= MODE_ALC;
        end else begin
            sel_prev <= sel_e;
            if (sel_e == SEL_OFF)
                mode_q <= alc_mode_e'(mode_in);
        end
    end

    alc_timer #(
        .HOLD_BASE(HOLD_BASE),
        .STEP_BASE(STEP_BASE),
        .HW(HW),
        .SW(SW)
    ) u_timer (
        .clk      (clk),
        .rst      (rst),
        .clr      (load),
        .tick     (tick),
        .over     (over),
        .hold_sel (hold_sel),
        .decay_sel(decay_sel),
        .up       (up)
    );

    alc_gain u_gain (
        .clk     (clk),
        .rst     (rst),
        .load    (load),
        .load_val(load_val),
        .down    (tick && over),
        .up      (up),
        .mode    (mode_q),
        .bnd     (bnd),
        .gain    (loop_gain)
    );

    // Bit 1 hands the left channel to the loop, bit 0 the right channel
    assign gain_l = sel[1] ? loop_gain : man_l;
    assign gain_r = sel[0] ? loop_gain : man_r;
endmodule

// File: rtl/alc_core_chk.sv
module alc_core_chk (
    input logic              clk,
    input logic              rst,
    input logic              smp_stb,
    input logic signed [7:0] level,
    input logic [1:0]        sel,
    input logic [2:0]        max_sel,
    input logic [2:0]        min_sel,
    input logic [3:0]        target_sel,
    input logic [5:0]        man_l,
    input logic [5:0]        man_r,
    input logic [5:0]        gain_l,
    input logic [5:0]        gain_r,
    input logic              active
);
    import alc_pkg::*;

    AST_OFF_MANUAL: assert property (@(posedge clk) disable iff (rst)
        !active |-> (gain_l == man_l && gain_r == man_r)); // R2

    AST_STEREO_SAME: assert property (@(posedge clk) disable iff (rst)
        (sel == 2'b11) |-> (gain_l == gain_r)); // R10

    AST_GAIN_BOUNDS: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && sel == 2'b10 && $past(sel) == 2'b10 &&
         min_code($past(min_sel)) <= max_code($past(max_sel)))
        |-> (gain_l <= max_code($past(max_sel)) && gain_l >= min_code($past(min_sel)))); // R3

    AST_ONE_STEP: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(rst, 2) && sel == 2'b10 && $past(sel) == 2'b10 &&
         $past(sel, 2) == 2'b10 && $past(max_sel) == $past(max_sel, 2) &&
         $past(min_sel) == $past(min_sel, 2))
        |-> (gain_l == $past(gain_l) || gain_l == $past(gain_l) + 6'd1 ||
             gain_l + 6'd1 == $past(gain_l))); // R11

    AST_ATTACK_NO_RISE: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(rst, 2) && sel == 2'b11 && $past(sel) == 2'b11 &&
         $past(sel, 2) == 2'b11 && $past(smp_stb) &&
         $past(level) > target_lvl($past(target_sel)) &&
         $past(max_sel) == $past(max_sel, 2) && $past(min_sel) == $past(min_sel, 2))
        |-> (gain_l <= $past(gain_l))); // R5
endmodule

bind alc_core alc_core_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .smp_stb   (smp_stb),
    .level     (level),
    .sel       (sel),
    .max_sel   (max_sel),
    .min_sel   (min_sel),
    .target_sel(target_sel),
    .man_l     (man_l),
    .man_r     (man_r),
    .gain_l    (gain_l),
    .gain_r    (gain_r),
    .active    (active)
);

// File: tb/sim_alc_core.sv
module sim_alc_core;
    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              smp_stb = 1'b0;
    logic signed [7:0] level = -8'sd60;
    logic [1:0]        sel = 2'b00;
    logic              mode_in = 1'b0;
    logic [2:0]        max_sel = 3'd7;
    logic [2:0]        min_sel = 3'd0;
    logic [3:0]        target_sel = 4'd11;
    logic [3:0]        hold_sel = 4'd0;
    logic [3:0]        decay_sel = 4'd0;
    logic [5:0]        man_l = 6'd10;
    logic [5:0]        man_r = 6'd20;
    logic [5:0]        gain_l, gain_r;
    logic              active;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    alc_core #(.HOLD_BASE(2), .STEP_BASE(3)) u0 (
        .clk(clk), .rst(rst), .smp_stb(smp_stb), .level(level), .sel(sel),
        .mode_in(mode_in), .max_sel(max_sel), .min_sel(min_sel),
        .target_sel(target_sel), .hold_sel(hold_sel), .decay_sel(decay_sel),
        .man_l(man_l), .man_r(man_r), .gain_l(gain_l), .gain_r(gain_r),
        .active(active)
    );

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic strobes(input int n);
        smp_stb = 1'b1;
        repeat (n) @(negedge clk);
        smp_stb = 1'b0;
    endtask

    task automatic enable(input logic [1:0] s);
        sel = 2'b00;
        @(negedge clk);
        sel = s;
        @(negedge clk);
    endtask

    task automatic t_reset;
        check("R1 active after reset", active, 0);
        check("R2 left manual", gain_l, 10);
        check("R2 right manual", gain_r, 20);
    endtask

    task automatic t_right_attack;
        man_l = 6'd5; man_r = 6'd30; level = 8'sd0;
        enable(2'b01);
        check("R1 active right", active, 1);
        check("R2 right loaded from man_r", gain_r, 30);
        check("R1 left stays manual", gain_l, 5);
        strobes(4);
        check("R5 attack four steps", gain_r, 26);
        min_sel = 3'd3;
        strobes(10);
        check("R4 floor code 24", gain_r, 24);
        min_sel = 3'd0;
    endtask

    task automatic t_hold_decay;
        man_l = 6'd20; hold_sel = 4'd2; decay_sel = 4'd0;
        level = -8'sd16;              // equal to target code 11: quiet
        enable(2'b10);
        strobes(6);
        check("R6 no rise inside hold plus step", gain_l, 20);
        strobes(1);
        check("R7 first rise", gain_l, 21);
        strobes(3);
        check("R7 second rise", gain_l, 22);
        level = -8'sd15;
        strobes(1);
        check("R5 one above target", gain_l, 21);
        level = -8'sd60;
        strobes(6);
        check("R6 hold restarted", gain_l, 21);
        strobes(1);
        check("R6 rise after restarted hold", gain_l, 22);
        hold_sel = 4'd0;
    endtask

    task automatic t_no_strobe;
        level = 8'sd0;
        repeat (10) @(negedge clk);
        check("R11 no change without strobe", gain_l, 22);
        level = -8'sd60;
    endtask

    task automatic t_max_clamp;
        man_l = 6'd20; max_sel = 3'd0;
        enable(2'b10);
        check("R3 load clamped to ceiling 7", gain_l, 7);
        strobes(30);
        check("R3 ceiling holds while quiet", gain_l, 7);
        max_sel = 3'd7;
    endtask

    task automatic t_stereo;
        man_l = 6'd40; man_r = 6'd40; level = 8'sd0;
        enable(2'b11);
        strobes(2);
        check("R10 left after attack", gain_l, 38);
        check("R10 right after attack", gain_r, 38);
        level = -8'sd60;
    endtask

    task automatic t_limiter;
        sel = 2'b00; mode_in = 1'b1;
        @(negedge clk);
        man_l = 6'd30; man_r = 6'd30;
        enable(2'b11);
        level = 8'sd0;
        strobes(1);
        check("R8 attack in limiter", gain_l, 29);
        level = -8'sd60;
        strobes(3);
        check("R8 recovers to ceiling", gain_l, 30);
        strobes(30);
        check("R8 never above ceiling", gain_l, 30);
    endtask

    task automatic t_mode_latch;
        sel = 2'b00; mode_in = 1'b0;
        @(negedge clk);
        man_l = 6'd30; man_r = 6'd30;
        enable(2'b11);
        mode_in = 1'b1;               // ignored while on
        level = 8'sd0;
        strobes(1);
        level = -8'sd60;
        strobes(6);
        check("R9 mode change ignored, ALC rises past 30", gain_l, 31);
        mode_in = 1'b0;
    endtask

    task automatic t_decay_sat;
        man_l = 6'd20; decay_sel = 4'd12;
        enable(2'b10);
        strobes(3071);
        check("R7 saturated step not yet", gain_l, 20);
        strobes(1);
        check("R7 saturated step at 3072", gain_l, 21);
        decay_sel = 4'd0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_right_attack();
        t_hold_decay();
        t_no_strobe();
        t_max_clamp();
        t_stereo();
        t_limiter();
        t_mode_latch();
        t_decay_sat();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule